// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors that each give their own guess. The first is a global one: a shift register of recent branch outcomes indexes a table of 2-bit counters. The second is a local one: a table of 2-bit counters indexed by the branch address. A third table of 2-bit counters, the chooser, is indexed by the branch address. It decides for each branch which component's guess becomes the final prediction.

The fetch side presents a PC on the lookup port. In the same cycle it receives the final direction and a flag that says which component supplied it. The resolve side later presents the PC and the real outcome on the update port. Both components learn from every update. The chooser learns only when one component was right and the other was wrong. Updates are assumed to arrive in program order. The block does not predict targets and does not repair speculative history.

Top module: `tourney_pred`

## Requirements
- R1: After reset, every component counter and every chooser entry holds 2'b01 and the history register holds zero, so any lookup returns lk_taken=0 with lk_use_global=0.
- R2: The lookup result is combinational from lk_pc. The chooser entry is selected by lk_pc[SEL_BITS+1:2], and an entry value of 2 or 3 selects the global component (lk_use_global=1), while 0 or 1 selects the local component.
- R3: lk_taken equals the direction of the chosen component's counter, and that direction is bit 1 of the counter (10 and 11 mean taken).
- R4: Component counters are 2-bit saturating. A taken outcome adds one and stops at 11, and a not-taken outcome subtracts one and stops at 00.
- R5: The local counter is selected by up_pc/lk_pc bits [LOC_BITS+1:2]. The global counter is selected by the full history register value.
- R6: Every update trains both the local and the global counter with the actual outcome, whichever component the chooser currently selects.
- R7: On update, the chooser entry at up_pc[SEL_BITS+1:2] adds one (saturating at 3) when only the global prediction was correct, and subtracts one (saturating at 0) when only the local prediction was correct. It is unchanged when both components were correct or both were wrong.
- R8: On update, the history register shifts left by one and takes up_taken into bit 0. The update's global index is the history value from before that shift.
- R9: An update becomes visible to lookups from the next clock cycle on. A lookup in the same cycle as an update sees the old state.
- R10: A cycle with up_valid=0 changes no table and no history, so repeated lookups of a PC give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction, 1 = taken |
| lk_use_global | output | 1 | 1 when the global component supplied lk_taken |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench builds the block with HIST_BITS, LOC_BITS and SEL_BITS all set to 4 and PC_W left at 32. With these values, branches 64 bytes apart share local and chooser entries, and the 16 history patterns recur quickly. This brings aliasing, chooser saturation at both ends and global-counter sharing between branches within a few thousand updates. A bench-side model of the three tables and the history register predicts every lookup. This covers directed saturation runs, an alternating branch that only the global side can learn, same-cycle lookup and update, and idle cycles.

// File: rtl/tourney_pkg.sv
// Package for the tournament predictor: counter type, reset value and
// the saturating step used by all three counter tables.
// Assumes: counters are exactly 2 bits wide.
package tourney_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_RESET = 2'b01;

    // Move a 2-bit counter one step up or down, clamping at both ends.
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
        ctr2_t nxt;
        if (up) begin
            nxt = (cur == 2'b11) ? cur : cur + 2'b01;
        end else begin
            nxt = (cur == 2'b00) ? cur : cur - 2'b01;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
// Table of 2-bit saturating counters with one combinational read port and
// one read-modify-write update port (read old value, step it, store it).
// Assumes: an update and a read to the same entry in one cycle return the
// old value on the read port; the new value is visible after the clock edge.
module tp_ctr_table
    import tourney_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_val,
    input  logic [IDX_W-1:0] up_idx,
    output ctr2_t            up_val,
    input  logic             up_we,
    input  logic             up_inc
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t cells [DEPTH];

    // Combinational reads for lookup and for the update's old value.
    always_comb begin
        rd_val = cells[rd_idx];
        up_val = cells[up_idx];
    end

    // Reset every counter, or step the addressed one on an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= CTR_RESET;
            end
        end else if (up_we) begin
            cells[up_idx] <= ctr_step(up_val, up_inc);
        end
    end

endmodule

// File: rtl/tp_hist_reg.sv
// Global outcome history: a shift register that takes the newest outcome
// into bit 0 on each update.
// Assumes: updates arrive in program order; no speculative repair.
module tp_hist_reg #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    // Clear on reset, shift the new outcome in on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[HIST_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/tourney_pred.sv
// Tournament direction predictor. A global component (history-indexed
// counters) and a local component (PC-indexed counters) each predict; a
// PC-indexed chooser of 2-bit counters picks one per branch. Updates train
// both components and move the chooser only when exactly one was correct.
// Assumes: word-aligned PCs (bits [1:0] unused), in-order updates,
// HIST_BITS >= 2, PC_W wide enough for every index field.
module tourney_pred
    import tourney_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int HIST_BITS = 10,
    parameter int LOC_BITS  = 10,
    parameter int SEL_BITS  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_use_global,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int PC_LSB = 2;

    logic [HIST_BITS-1:0] ghr;
    logic [LOC_BITS-1:0]  loc_lk_idx, loc_up_idx;
    logic [SEL_BITS-1:0]  sel_lk_idx, sel_up_idx;

    ctr2_t g_lk, g_up, l_lk, l_up, s_lk, s_up;
    logic  g_ok, l_ok, sel_we;

    // Slice the address fields used to index the local and chooser tables.
    always_comb begin
        loc_lk_idx = lk_pc[PC_LSB +: LOC_BITS];
        loc_up_idx = up_pc[PC_LSB +: LOC_BITS];
        sel_lk_idx = lk_pc[PC_LSB +: SEL_BITS];
        sel_up_idx = up_pc[PC_LSB +: SEL_BITS];
    end

    tp_hist_reg #(.HIST_W(HIST_BITS)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist     (ghr)
    );

    tp_ctr_table #(.IDX_W(HIST_BITS)) u_gtab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghr),
        .rd_val (g_lk),
        .up_idx (ghr),
        .up_val (g_up),
        .up_we  (up_valid),
        .up_inc (up_taken)
    );

    tp_ctr_table #(.IDX_W(LOC_BITS)) u_ltab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (loc_lk_idx),
        .rd_val (l_lk),
        .up_idx (loc_up_idx),
        .up_val (l_up),
        .up_we  (up_valid),
        .up_inc (up_taken)
    );

    // Grade each component's pre-update guess against the outcome.
    always_comb begin
        g_ok   = (g_up[1] == up_taken);
        l_ok   = (l_up[1] == up_taken);
        sel_we = up_valid && (g_ok != l_ok);
    end

    tp_ctr_table #(.IDX_W(SEL_BITS)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (sel_lk_idx),
        .rd_val (s_lk),
        .up_idx (sel_up_idx),
        .up_val (s_up),
        .up_we  (sel_we),
        .up_inc (g_ok)
    );

    // Pick the final direction from the component the chooser favours.
    always_comb begin
        lk_use_global = s_lk[1];
        lk_taken      = lk_use_global ? g_lk[1] : l_lk[1];
    end

endmodule

// File: rtl/tourney_pred_chk.sv
// Checker for tourney_pred: history shifting, idle stability, chooser
// write gating, agreement pass-through and reset state.
// Assumes: bound into tourney_pred and sees its internal nets by name.
module tourney_pred_chk #(
    parameter int PC_W      = 32,
    parameter int HIST_BITS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PC_W-1:0]      lk_pc,
    input logic                 lk_taken,
    input logic                 lk_use_global,
    input logic                 up_valid,
    input logic                 up_taken,
    input logic [HIST_BITS-1:0] ghr,
    input logic [1:0]           g_lk,
    input logic [1:0]           l_lk,
    input logic [1:0]           g_up,
    input logic [1:0]           l_up,
    input logic                 sel_we
);
    // R1: one cycle after reset is sampled, the lookup shows the reset state.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!lk_taken && !lk_use_global));

    // R3: when both components agree, the final result is their direction.
    p_agree_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (g_lk[1] == l_lk[1]) |-> (lk_taken == g_lk[1]));

    // R7: the chooser is written only on an update where the components differ.
    p_sel_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |-> (up_valid && (g_up[1] != l_up[1])));

    // R8: an update shifts the outcome into the history.
    p_hist_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (ghr == {$past(ghr[HIST_BITS-2:0]), $past(up_taken)}));

    // R10: no update leaves the history alone.
    p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghr));

    // R10: with no update and the same PC, the lookup result repeats.
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid ##1 $stable(lk_pc)) |-> ($stable(lk_taken) && $stable(lk_use_global)));

endmodule

bind tourney_pred tourney_pred_chk #(
    .PC_W      (PC_W),
    .HIST_BITS (HIST_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_pc         (lk_pc),
    .lk_taken      (lk_taken),
    .lk_use_global (lk_use_global),
    .up_valid      (up_valid),
    .up_taken      (up_taken),
    .ghr           (ghr),
    .g_lk          (g_lk),
    .l_lk          (l_lk),
    .g_up          (g_up),
    .l_up          (l_up),
    .sel_we        (sel_we)
);

// File: tb/tourney_pred_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver computes each lookup's expected result from
// a bench-side model and queues it; a monitor compares after the inputs settle.
module tourney_pred_test;
    localparam int PC_W = 32;
    localparam int HB   = 4;
    localparam int LB   = 4;
    localparam int SB   = 4;

    typedef struct {
        logic  taken;
        logic  glob;
        string tag;
    } exp_t;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken, lk_use_global;
    logic            up_valid = 0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    int m_g[1<<HB];
    int m_l[1<<LB];
    int m_s[1<<SB];
    int m_h;
    logic [15:0] lfsr = 16'hACE1;

    tourney_pred #(.PC_W(PC_W), .HIST_BITS(HB), .LOC_BITS(LB), .SEL_BITS(SB)) uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_use_global(lk_use_global), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken)
    );

    always #2 clk = ~clk;

    function automatic int sat(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic model_reset();
        foreach (m_g[i]) m_g[i] = 1;
        foreach (m_l[i]) m_l[i] = 1;
        foreach (m_s[i]) m_s[i] = 1;
        m_h = 0;
    endtask

    // Drive one cycle: lookup lpc, optional update (upc, t); queue expectation.
    task automatic step(input logic [PC_W-1:0] lpc, input bit v,
                        input logic [PC_W-1:0] upc, input bit t, input string tag);
        exp_t e;
        int li, si, ul, us, gv, lv;
        @(negedge clk);
        lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
        li = int'(lpc[2 +: LB]);
        si = int'(lpc[2 +: SB]);
        e.glob  = (m_s[si] >= 2);
        e.taken = e.glob ? (m_g[m_h] >= 2) : (m_l[li] >= 2);
        e.tag   = tag;
        q.push_back(e);
        if (v) begin
            ul = int'(upc[2 +: LB]);
            us = int'(upc[2 +: SB]);
            gv = m_g[m_h];
            lv = m_l[ul];
            if (((gv >= 2) == t) && !((lv >= 2) == t)) m_s[us] = sat(m_s[us], 1);
            if (!((gv >= 2) == t) && ((lv >= 2) == t)) m_s[us] = sat(m_s[us], 0);
            m_g[m_h] = sat(gv, t);
            m_l[ul]  = sat(lv, t);
            m_h = ((m_h << 1) | int'(t)) & ((1 << HB) - 1);
        end
    endtask

    // Monitor: compare queued expectations after inputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (lk_taken !== e.taken || lk_use_global !== e.glob) begin
                    errors++;
                    $display("FAIL %s: taken/glob actual %b/%b expected %b/%b",
                             e.tag, lk_taken, lk_use_global, e.taken, e.glob);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pa, pb, pc_al;
        pa = 32'h0000_0100;
        pb = 32'h0000_0208;
        pc_al = pa + 32'h40; // aliases pa in the 4-bit local and chooser tables
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state seen on several PCs without updates.
        step(pa, 0, '0, 0, "R1 reset lookup");
        step(pb, 0, '0, 0, "R1 reset lookup");
        step(32'hFFFF_FFFC, 0, '0, 0, "R1 reset lookup");

        // R4 R6: taken run saturates, one not-taken does not flip the prediction.
        for (int i = 0; i < 6; i++) step(pa, 1, pa, 1, "R4 R6 taken run");
        step(pa, 1, pa, 0, "R4 single not-taken");
        step(pa, 0, '0, 0, "R4 saturated still taken");
        for (int i = 0; i < 5; i++) step(pa, 1, pa, 0, "R4 not-taken run");
        step(pa, 0, '0, 0, "R4 floor reached");

        // R9: same-cycle lookup and update of one PC sees old state.
        step(pb, 1, pb, 1, "R9 same cycle old");
        step(pb, 1, pb, 1, "R9 after one update");
        step(pb, 0, '0, 0, "R9 after two updates");

        // R2 R3 R7 R8: alternating branch only global history can learn.
        for (int i = 0; i < 60; i++) step(pb, 1, pb, (i % 2) == 0, "R2 R3 R7 R8 alternating");

        // R5: aliasing PC shares local and chooser entries.
        for (int i = 0; i < 8; i++) step(pc_al, 1, pa, 1, "R5 alias train");
        step(pc_al, 0, '0, 0, "R5 alias read");

        // R10: idle cycles leave everything unchanged.
        for (int i = 0; i < 6; i++) step((i % 2) ? pa : pb, 0, pb, 1, "R10 idle");

        // R2 R3 R5 R6 R7 R8: pseudo-random mix over 8 branches, biased outcomes.
        for (int i = 0; i < 4000; i++) begin
            logic [PC_W-1:0] rp, lp;
            bit t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rp = 32'h1000 + {26'd0, lfsr[2:0], 3'd0} * 32'd4;
            lp = 32'h1000 + {26'd0, lfsr[7:5], 3'd0} * 32'd4;
            t  = lfsr[2] ? (lfsr[11:9] != 3'd0) : (lfsr[11:9] == 3'd0);
            if (lfsr[0]) t = ~m_h[0];
            step(lp, lfsr[14:12] != 3'd0, rp, t, "R2 R3 R5 R6 R7 R8 mix");
        end

        // R1: reset again restores the initial state.
        @(negedge clk);
        up_valid = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        step(pa, 0, '0, 0, "R1 re-reset lookup");
        step(pb, 0, '0, 0, "R1 re-reset lookup");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule